// File: doc/BRIEF.md
# Two-Channel Cascaded Biquad Equalizer

This block filters two audio channels through a chain of four programmable second-order IIR sections per channel. A frame strobe captures one signed 24-bit sample per channel. The block then runs both channels through their sections on a single shared multiply-accumulate unit, one product per clock. A one-cycle done pulse marks the point where both results are on the output bus.

Coefficients sit in an on-chip bank that a host writes and reads back through a plain address/data port. Three of the five coefficients of each section are stored at half their true value, and the datapath doubles their products. This lets a gain of up to almost 2 be held in a fractional word. A link control makes both channels filter with the first channel's coefficient set. A per-channel bypass control passes a channel's sample straight through.

Top module: `biquad_eq2`

## Requirements
- R1: After reset, `y_out` is zero, `done` is low, every coefficient reads back as zero and all section history is zero, so a frame processed before any coefficient write yields zero on both channels.
- R2: Coefficient word k of section s for channel c lives at address 20*c + 5*s + k, with k = 0 for b0/2, 1 for b1/2, 2 for b2, 3 for a1/2 and 4 for a2. A write happens on a clock edge with `coef_we` high. `coef_rdata` shows the word at `coef_addr` without a clock. Addresses 40 to 63 read as zero and writes to them are dropped.
- R3: Each section forms acc = 2*(b0/2)*x[n] + 2*(b1/2)*x[n-1] + b2*x[n-2] - 2*(a1/2)*y[n-1] - a2*y[n-2] with all values as 24-bit two's-complement integers, and its result is acc shifted right arithmetically by 23 (rounding toward minus infinity).
- R4: A section result above 8388607 is output as 8388607, and one below -8388608 as -8388608, with no wrap.
- R5: The four sections of a channel run in series (the output of section s feeds section s+1), and each section keeps its own x[n-1], x[n-2], y[n-1], y[n-2] per channel from frame to frame.
- R6: With `link_en` high, both channels use the coefficients at addresses 0 to 19, while each channel keeps its own history.
- R7: With `bypass[c]` high during a frame, that channel's output equals its input sample, and its section history is left as it was.
- R8: `frame_go` is acted on only while idle. `done` is high for exactly one cycle per accepted frame, with both outputs valid in that cycle. A `frame_go` during processing neither changes the captured samples nor causes an extra `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| coef_we | input | 1 | Coefficient write enable |
| coef_addr | input | 6 | Coefficient word address |
| coef_wdata | input | 24 | Coefficient write data |
| coef_rdata | output | 24 | Coefficient read data at `coef_addr` |
| link_en | input | 1 | Both channels use the channel-0 coefficient set |
| bypass | input | 2 | Per-channel equalizer bypass, bit c for channel c |
| frame_go | input | 1 | Frame strobe: capture inputs and start |
| x_in | input | 48 | Input samples, channel c in bits [24c+23:24c] |
| y_out | output | 48 | Output samples, same packing as `x_in` |
| done | output | 1 | One-cycle pulse when both outputs are ready |

## Verification
The bench walks a table of impulses, steps and sign changes through the chain and compares the results against an integer model of the section equation. A design that forgot the doubling of the half-value terms, or mixed up the tap order, would diverge on the first impulse. Small positive and negative inputs through unity-ish gains test the rounding toward minus infinity, and full-scale inputs through a gain of two test the clamp at both rails; a wrapping or truncating-toward-zero design gives results that differ by sign or by one. Further cases cover linked coefficients, a bypassed frame followed by a normal one (which shows whether history was wrongly advanced), out-of-range coefficient addresses, and a strobe issued mid-frame, which would corrupt the captured samples or produce a second done pulse in a careless sequencer.

// File: rtl/eq_pkg.sv
package eq_pkg;

   // number of coefficient words (and multiply-accumulate steps) per section
   localparam int EQ_TAPS = 5;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOAD,
      ST_MAC,
      ST_WB,
      ST_FIN
   } eq_state_t;

endpackage

// File: rtl/eq_coef_bank.sv
module eq_coef_bank import eq_pkg::*; #(
   parameter int NCH  = 2,
   parameter int NSEC = 4,
   parameter int CW   = 24,
   localparam int NWORD = NCH * NSEC * EQ_TAPS,
   localparam int AW    = $clog2(NWORD)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] host_addr,
   input  logic [CW-1:0] wr_data,
   output logic [CW-1:0] host_rdata,
   input  logic [AW-1:0] dp_addr,
   output logic [CW-1:0] dp_rdata
);

   localparam logic [AW:0] LIMIT = (AW+1)'(NWORD);

   logic [CW-1:0] mem [NWORD];
   logic          host_ok;
   logic          dp_ok;

   assign host_ok = {1'b0, host_addr} < LIMIT;
   assign dp_ok   = {1'b0, dp_addr} < LIMIT;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NWORD; i++) mem[i] <= '0;
      end else if (wr_en && host_ok) begin
         mem[host_addr] <= wr_data;
      end
   end

   assign host_rdata = host_ok ? mem[host_addr] : '0;
   assign dp_rdata   = dp_ok   ? mem[dp_addr]   : '0;

endmodule

// File: rtl/eq_mac.sv
module eq_mac #(
   parameter int DW   = 24,
   parameter int CW   = 24,
   parameter int ACCW = 56
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 en,
   input  logic                 clr,
   input  logic                 dbl,
   input  logic                 neg,
   input  logic signed [DW-1:0] smp,
   input  logic signed [CW-1:0] cof,
   output logic signed [DW-1:0] y_sat
);

   localparam logic signed [ACCW-1:0] Y_MAX = {{(ACCW-DW+1){1'b0}}, {(DW-1){1'b1}}};
   localparam logic signed [ACCW-1:0] Y_MIN = {{(ACCW-DW+1){1'b1}}, {(DW-1){1'b0}}};

   logic signed [DW+CW-1:0] prod;
   logic signed [ACCW-1:0]  term;
   logic signed [ACCW-1:0]  acc_q;
   logic signed [ACCW-1:0]  scaled;

   always_comb begin
      prod = smp * cof;
      term = ACCW'(prod);
      if (dbl) term = term <<< 1;
      if (neg) term = -term;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)   acc_q <= '0;
      else if (en)  acc_q <= clr ? term : acc_q + term;
   end

   // back to the sample format: drop the fractional bits of the coefficient
   assign scaled = acc_q >>> (CW - 1);

   always_comb begin
      if (scaled > Y_MAX)      y_sat = Y_MAX[DW-1:0];
      else if (scaled < Y_MIN) y_sat = Y_MIN[DW-1:0];
      else                     y_sat = scaled[DW-1:0];
   end

endmodule

// File: rtl/eq_seq.sv
module eq_seq import eq_pkg::*; #(
   parameter int NCH  = 2,
   parameter int NSEC = 4,
   localparam int CHW  = $clog2(NCH),
   localparam int SECW = $clog2(NSEC)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            go,
   input  logic [NCH-1:0]  bypass,
   output eq_state_t       st,
   output logic [CHW-1:0]  ch,
   output logic [SECW-1:0] sec,
   output logic [2:0]      tap
);

   localparam logic [CHW-1:0]  CH_LAST  = CHW'(NCH - 1);
   localparam logic [SECW-1:0] SEC_LAST = SECW'(NSEC - 1);
   localparam logic [2:0]      TAP_LAST = 3'(EQ_TAPS - 1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st  <= ST_IDLE;
         ch  <= '0;
         sec <= '0;
         tap <= '0;
      end else begin
         case (st)
            ST_IDLE: begin
               if (go) begin
                  st <= ST_LOAD;
                  ch <= '0;
               end
            end
            ST_LOAD: begin
               sec <= '0;
               tap <= '0;
               if (bypass[ch]) begin
                  if (ch == CH_LAST) st <= ST_FIN;
                  else               ch <= ch + 1'b1;
               end else begin
                  st <= ST_MAC;
               end
            end
            ST_MAC: begin
               if (tap == TAP_LAST) st <= ST_WB;
               else                 tap <= tap + 3'd1;
            end
            ST_WB: begin
               tap <= '0;
               if (sec == SEC_LAST) begin
                  if (ch == CH_LAST) begin
                     st <= ST_FIN;
                  end else begin
                     ch <= ch + 1'b1;
                     st <= ST_LOAD;
                  end
               end else begin
                  sec <= sec + 1'b1;
                  st  <= ST_MAC;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/biquad_eq2.sv
module biquad_eq2 import eq_pkg::*; #(
   parameter int NCH  = 2,
   parameter int NSEC = 4,
   parameter int DW   = 24,
   parameter int CW   = 24,
   parameter int ACCW = 56,
   localparam int NWORD = NCH * NSEC * EQ_TAPS,
   localparam int AW    = $clog2(NWORD)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              coef_we,
   input  logic [AW-1:0]     coef_addr,
   input  logic [CW-1:0]     coef_wdata,
   output logic [CW-1:0]     coef_rdata,
   input  logic              link_en,
   input  logic [NCH-1:0]    bypass,
   input  logic              frame_go,
   input  logic [NCH*DW-1:0] x_in,
   output logic [NCH*DW-1:0] y_out,
   output logic              done
);

   localparam int CHW  = $clog2(NCH);
   localparam int SECW = $clog2(NSEC);
   localparam logic [SECW-1:0] SEC_LAST = SECW'(NSEC - 1);

   // elaboration-time parameter checks
   if (NCH < 2)            begin : g_bad_nch  $error("NCH must be at least 2");   end
   if (NSEC < 2)           begin : g_bad_nsec $error("NSEC must be at least 2");  end
   if (CW < 2 || DW < 2)   begin : g_bad_w    $error("DW and CW must exceed 1");  end
   if (ACCW < DW + CW + 4) begin : g_bad_acc  $error("ACCW needs guard bits");    end

   eq_state_t        st;
   logic [CHW-1:0]   ch;
   logic [SECW-1:0]  sec;
   logic [2:0]       tap;
   logic [AW-1:0]    dp_addr;
   logic [CW-1:0]    dp_coef;
   logic [CHW-1:0]   bank;

   logic signed [DW-1:0] x_unp [NCH];
   logic signed [DW-1:0] x_lat [NCH];
   logic signed [DW-1:0] y_q   [NCH];
   logic signed [DW-1:0] hx1   [NCH][NSEC];
   logic signed [DW-1:0] hx2   [NCH][NSEC];
   logic signed [DW-1:0] hy1   [NCH][NSEC];
   logic signed [DW-1:0] hy2   [NCH][NSEC];
   logic signed [DW-1:0] cur;
   logic signed [DW-1:0] smp;
   logic signed [DW-1:0] y_sat;
   logic                 dbl;
   logic                 neg;
   logic                 done_q;

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      assign x_unp[c]           = x_in[c*DW +: DW];
      assign y_out[c*DW +: DW]  = y_q[c];
   end

   eq_seq #(.NCH(NCH), .NSEC(NSEC)) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .go     (frame_go),
      .bypass (bypass),
      .st     (st),
      .ch     (ch),
      .sec    (sec),
      .tap    (tap)
   );

   // coefficient fetch: linked channels share bank 0
   always_comb begin
      bank    = link_en ? '0 : ch;
      dp_addr = AW'(int'(bank) * NSEC * EQ_TAPS + int'(sec) * EQ_TAPS + int'(tap));
   end

   eq_coef_bank #(.NCH(NCH), .NSEC(NSEC), .CW(CW)) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (coef_we),
      .host_addr  (coef_addr),
      .wr_data    (coef_wdata),
      .host_rdata (coef_rdata),
      .dp_addr    (dp_addr),
      .dp_rdata   (dp_coef)
   );

   // operand select: tap order b0, b1, b2, a1, a2
   always_comb begin
      case (tap)
         3'd0:    smp = cur;
         3'd1:    smp = hx1[ch][sec];
         3'd2:    smp = hx2[ch][sec];
         3'd3:    smp = hy1[ch][sec];
         default: smp = hy2[ch][sec];
      endcase
      dbl = (tap == 3'd0) || (tap == 3'd1) || (tap == 3'd3);
      neg = (tap >= 3'd3);
   end

   eq_mac #(.DW(DW), .CW(CW), .ACCW(ACCW)) u_mac (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (st == ST_MAC),
      .clr   (tap == 3'd0),
      .dbl   (dbl),
      .neg   (neg),
      .smp   (smp),
      .cof   (dp_coef),
      .y_sat (y_sat)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int c = 0; c < NCH; c++) begin
            x_lat[c] <= '0;
            y_q[c]   <= '0;
            for (int s = 0; s < NSEC; s++) begin
               hx1[c][s] <= '0;
               hx2[c][s] <= '0;
               hy1[c][s] <= '0;
               hy2[c][s] <= '0;
            end
         end
         cur    <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= (st == ST_FIN);
         case (st)
            ST_IDLE: begin
               if (frame_go) begin
                  for (int c = 0; c < NCH; c++) x_lat[c] <= x_unp[c];
               end
            end
            ST_LOAD: begin
               cur <= x_lat[ch];
               if (bypass[ch]) y_q[ch] <= x_lat[ch];
            end
            ST_WB: begin
               hx2[ch][sec] <= hx1[ch][sec];
               hx1[ch][sec] <= cur;
               hy2[ch][sec] <= hy1[ch][sec];
               hy1[ch][sec] <= y_sat;
               cur          <= y_sat;
               if (sec == SEC_LAST) y_q[ch] <= y_sat;
            end
            default: ;
         endcase
      end
   end

   assign done = done_q;

endmodule

// File: rtl/eq_chk.sv
module eq_chk import eq_pkg::*; #(
   parameter int NCH  = 2,
   parameter int NSEC = 4,
   parameter int DW   = 24,
   parameter int AW   = 6,
   parameter int CHW  = 1
) (
   input logic              clk,
   input logic              rst_n,
   input eq_state_t         st,
   input logic [CHW-1:0]    ch,
   input logic [2:0]        tap,
   input logic              link_en,
   input logic [AW-1:0]     dp_addr,
   input logic              done,
   input logic [NCH*DW-1:0] y_out
);

   localparam logic [AW-1:0] BANK0_END = AW'(NSEC * EQ_TAPS);

   // R8: done lasts a single cycle
   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R8: leaving the final state always produces done
   p_fin_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_FIN) |=> done);

   // R8: outputs do not move while idle
   p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE) |=> $stable(y_out));

   // R8: a strobe while busy never restarts at channel 0
   p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (st != ST_IDLE) |=> !(st == ST_LOAD && ch == '0));

   // R6: linked fetches stay inside the first channel's bank
   p_link_bank_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_MAC && link_en) |-> (dp_addr < BANK0_END));

   // R3: five product steps per section, never more
   p_tap_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_MAC) |-> (tap < 3'(EQ_TAPS)));

endmodule

bind biquad_eq2 eq_chk #(
   .NCH(NCH), .NSEC(NSEC), .DW(DW), .AW(AW), .CHW(CHW)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .st      (st),
   .ch      (ch),
   .tap     (tap),
   .link_en (link_en),
   .dp_addr (dp_addr),
   .done    (done),
   .y_out   (y_out)
);

// File: tb/biquad_eq2_tb.sv
module biquad_eq2_tb;

   localparam int NCH = 2, NSEC = 4, DW = 24, NW = 40;
   localparam int NSTIM = 12;
   localparam int STIM [NSTIM][2] = '{
      '{4194304, 0}, '{0, 4194304}, '{0, 0}, '{0, 0},
      '{1000000, -1000000}, '{1000000, -1000000}, '{1000000, -1000000},
      '{-3000000, 2500000}, '{7000000, -7000000}, '{-8388608, 8388607},
      '{12345, -54321}, '{0, 0}
   };

   logic          clk = 1'b0;
   logic          rst_n;
   logic          coef_we;
   logic [5:0]    coef_addr;
   logic [23:0]   coef_wdata;
   logic [23:0]   coef_rdata;
   logic          link_en;
   logic [1:0]    bypass;
   logic          frame_go;
   logic [47:0]   x_in;
   logic [47:0]   y_out;
   logic          done;

   always #4 clk = ~clk;

   biquad_eq2 u_dut (
      .clk(clk), .rst_n(rst_n), .coef_we(coef_we), .coef_addr(coef_addr),
      .coef_wdata(coef_wdata), .coef_rdata(coef_rdata), .link_en(link_en),
      .bypass(bypass), .frame_go(frame_go), .x_in(x_in), .y_out(y_out), .done(done)
   );

   int n_run = 0;
   int n_fail = 0;

   longint cf [NW];
   longint sx1 [NCH][NSEC];
   longint sx2 [NCH][NSEC];
   longint sy1 [NCH][NSEC];
   longint sy2 [NCH][NSEC];
   bit     m_link = 0;
   bit [1:0] m_byp = 2'b00;

   function automatic longint s24(logic [23:0] v);
      return longint'($signed(v));
   endfunction

   function automatic longint clamp24(longint v);
      if (v > 8388607)  return 8388607;
      if (v < -8388608) return -8388608;
      return v;
   endfunction

   function automatic longint model_ch(int c, longint x);
      longint s, acc, y;
      int b;
      if (m_byp[c]) return x;
      s = x;
      for (int k = 0; k < NSEC; k++) begin
         b = (m_link ? 0 : c) * 20 + k * 5;
         acc = 2 * cf[b] * s + 2 * cf[b+1] * sx1[c][k] + cf[b+2] * sx2[c][k]
             - 2 * cf[b+3] * sy1[c][k] - cf[b+4] * sy2[c][k];
         y = clamp24(acc >>> 23);
         sx2[c][k] = sx1[c][k];
         sx1[c][k] = s;
         sy2[c][k] = sy1[c][k];
         sy1[c][k] = y;
         s = y;
      end
      return s;
   endfunction

   task automatic check(string tag, longint act, longint exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic wr(int a, longint v);
      @(negedge clk);
      coef_we    = 1'b1;
      coef_addr  = 6'(a);
      coef_wdata = v[23:0];
      @(negedge clk);
      coef_we = 1'b0;
      if (a < NW) cf[a] = s24(v[23:0]);
   endtask

   task automatic start(longint a, longint b);
      @(negedge clk);
      x_in     = {b[23:0], a[23:0]};
      frame_go = 1'b1;
      @(negedge clk);
      frame_go = 1'b0;
   endtask

   task automatic wait_done();
      int k = 0;
      while (!done && k < 300) begin
         @(negedge clk);
         k++;
      end
      check("R8 done seen", longint'(done), 1);
   endtask

   task automatic frame_chk(string tag, longint a, longint b);
      longint e0, e1;
      start(a, b);
      wait_done();
      e0 = model_ch(0, a);
      e1 = model_ch(1, b);
      check({tag, " ch0"}, s24(y_out[23:0]), e0);
      check({tag, " ch1"}, s24(y_out[47:24]), e1);
      @(negedge clk);
      check("R8 done one cycle", longint'(done), 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      int dcount;
      for (int a = 0; a < NW; a++) cf[a] = 0;
      for (int c = 0; c < NCH; c++)
         for (int s = 0; s < NSEC; s++) begin
            sx1[c][s] = 0; sx2[c][s] = 0; sy1[c][s] = 0; sy2[c][s] = 0;
         end
      rst_n = 1'b0; coef_we = 1'b0; coef_addr = 6'd7; coef_wdata = '0;
      link_en = 1'b0; bypass = 2'b00; frame_go = 1'b0; x_in = '0;
      repeat (4) @(negedge clk);
      // R1: reset state
      check("R1 y_out reset", longint'(y_out), 0);
      check("R1 done reset", longint'(done), 0);
      check("R1 coef reset", longint'(coef_rdata), 0);
      rst_n = 1'b1;
      // R1: cleared coefficients give zero output
      frame_chk("R1 zero coef", 1000, -1000);

      // R2: program both banks
      for (int c = 0; c < NCH; c++)
         for (int s = 0; s < NSEC; s++) begin
            wr(c*20 + s*5 + 0, 64'sh200000 + s*64'sh020000 - c*64'sh050000);
            wr(c*20 + s*5 + 1, 64'sh0C0000 - c*64'sh180000);
            wr(c*20 + s*5 + 2, 64'sh040000 + s*64'sh008000);
            wr(c*20 + s*5 + 3, -(64'sh0E0000 + c*64'sh040000));
            wr(c*20 + s*5 + 4, 64'sh060000);
         end
      foreach (STIM[i]) begin end
      for (int a = 0; a < NW; a += 13) begin
         @(negedge clk); coef_addr = 6'(a); #2;
         check("R2 readback", s24(coef_rdata), cf[a]);
      end
      wr(45, 64'sh123456);
      @(negedge clk); coef_addr = 6'd45; #2;
      check("R2 out of range", longint'(coef_rdata), 0);

      // R3 R5: table of stimulus walked in one loop
      for (int i = 0; i < NSTIM; i++)
         frame_chk("R3 R5 table", STIM[i][0], STIM[i][1]);

      // R4 R3: channel 1 sections become gain-of-two stages
      for (int s = 0; s < NSEC; s++)
         for (int k = 0; k < 5; k++)
            wr(20 + s*5 + k, (k == 0) ? 64'sh7FFFFF : 0);
      start(0, 6291456); wait_done();
      check("R4 positive clamp", s24(y_out[47:24]), 8388607);
      void'(model_ch(0, 0)); void'(model_ch(1, 6291456));
      start(0, -6291456); wait_done();
      check("R4 negative clamp", s24(y_out[47:24]), -8388608);
      void'(model_ch(0, 0)); void'(model_ch(1, -6291456));
      start(0, 3); wait_done();
      check("R3 floor positive", s24(y_out[47:24]), 33);
      void'(model_ch(0, 0)); void'(model_ch(1, 3));
      start(0, -3); wait_done();
      check("R3 floor negative", s24(y_out[47:24]), -48);
      void'(model_ch(0, 0)); void'(model_ch(1, -3));

      // R6: linked coefficients
      link_en = 1'b1; m_link = 1'b1;
      frame_chk("R6 link", 2000000, 2000000);
      frame_chk("R6 link", -500000, 300000);
      link_en = 1'b0; m_link = 1'b0;

      // R7: bypass channel 0, then resume with untouched history
      bypass = 2'b01; m_byp = 2'b01;
      frame_chk("R7 bypass", -1234567, 5);
      check("R7 passthrough", s24(y_out[23:0]), -1234567);
      bypass = 2'b00; m_byp = 2'b00;
      frame_chk("R7 history kept", 700000, 5);

      // R8: strobe during processing is ignored
      start(400000, -400000);
      repeat (5) @(negedge clk);
      x_in = {24'h100000, 24'h100000};
      frame_go = 1'b1;
      @(negedge clk);
      frame_go = 1'b0;
      wait_done();
      check("R8 busy ch0", s24(y_out[23:0]), model_ch(0, 400000));
      check("R8 busy ch1", s24(y_out[47:24]), model_ch(1, -400000));
      dcount = 0;
      for (int k = 0; k < 80; k++) begin
         @(negedge clk);
         if (done) dcount++;
      end
      check("R8 no extra done", dcount, 0);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule